// File: doc/BRIEF.md
# Platform Status and Control Register Window

This block is a 4 KB memory-mapped window that software reads to learn how the board is configured. It also accepts one command: a soft system reset. Each access is a single cycle with a valid strobe. The block decodes the word index from address bits 11:2. It answers reads from that index combinationally, using words that are either constant or built from two live inputs: the timer clock rate in MHz and the installed memory size in gigabytes.

Only aligned 32-bit accesses are serviced. Any access with the wrong size, a misaligned address or an unknown index returns zero, has no effect and raises an unimplemented flag in the same cycle. Writes to the read-only status words are dropped without a flag. A write to the reset-control word with the command bit set produces a one-cycle reset request on the next clock edge.

Top module: `plat_regfile`

## Requirements
- R1: An access whose size (byte count on `acc_size`) is not 4 reads as zero, changes nothing, never requests a reset and raises `unimpl` in the same cycle.
- R2: Aligned 32-bit reads at offsets 0x000, 0x004 and 0x008 return zero without raising `unimpl`.
- R3: A read at offset 0x014 returns 0x00000005. This is the memory-status word: bit 0 means locked and bit 2 means calibrated.
- R4: A read at offset 0x030 returns the clock-divider word. Bits 7:0 read 1, bits 15:8 hold `clk_mhz`, bits 23:16 read 1 and bits 31:24 read 1.
- R5: A read at offset 0x034 returns 0x0000000E. Bits 1, 2 and 3 are the three PCIe-enable bits and are set. Bit 0 is the coherence-unit enable and is clear.
- R6: A read at offset 0x038 returns `mem_gb` in bits 3:0, ones in bits 15:4 and zero in bits 31:16.
- R7: An aligned 32-bit write to offset 0x010 with data bit 4 set drives `rst_req` high for exactly the one cycle after the write edge. The same write with bit 4 clear leaves `rst_req` low.
- R8: Aligned 32-bit writes to offsets 0x000, 0x004, 0x008, 0x014, 0x018, 0x030, 0x034 and 0x038 are dropped. They raise no `unimpl`, request no reset and leave later reads of those words unchanged.
- R9: An aligned 32-bit access to any other offset is unimplemented. This includes reads of 0x010 and 0x018. A read returns zero, a write does nothing, and `unimpl` is raised.
- R10: An access with address bits 1:0 non-zero is unimplemented. It reads zero, writes nothing and raises `unimpl`.
- R11: When `acc_valid` is low, and during any write, `rd_data` is zero. `unimpl` is low whenever `acc_valid` is low. `rst_req` is low out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_size | input | 4 | Access size in bytes |
| acc_addr | input | 12 | Byte offset within the window |
| acc_wdata | input | 32 | Write data |
| clk_mhz | input | 8 | Timer clock frequency in MHz |
| mem_gb | input | 4 | Installed memory in GB |
| rd_data | output | 32 | Read data, valid in the access cycle |
| rst_req | output | 1 | One-cycle system-reset request |
| unimpl | output | 1 | Access was unimplemented |

## Verification
The assertions assume that `acc_valid`, `acc_wr`, `acc_size`, `acc_addr` and `acc_wdata` are steady around each rising edge. They also assume that `clk_mhz` and `mem_gb` are quasi-static board values. The read-data properties depend on both of these assumptions.

The stimulus meets these assumptions as follows. It changes bus inputs only on falling edges. It changes the two board inputs only while `acc_valid` is low. It keeps `mem_gb` within its 4-bit field, so the encoded size never spills into the speed bits.

// File: rtl/plat_regfile_pkg.sv
package plat_regfile_pkg;

   // Word indices (byte offset / 4) with architected meaning
   localparam int WIX_ID_A    = 0;
   localparam int WIX_ID_B    = 1;
   localparam int WIX_ID_C    = 2;
   localparam int WIX_RSTCTL  = 4;
   localparam int WIX_MEMSTAT = 5;
   localparam int WIX_LINKST  = 6;
   localparam int WIX_CLKDIV  = 12;
   localparam int WIX_BUILD   = 13;
   localparam int WIX_MEMCFG  = 14;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ZERO,
      SEL_MEMSTAT,
      SEL_CLKDIV,
      SEL_BUILD,
      SEL_MEMCFG,
      SEL_RSTCTL,
      SEL_DROP
   } sel_e;

endpackage

// File: rtl/plat_regfile_decode.sv
module plat_regfile_decode
   import plat_regfile_pkg::*;
#(
   parameter int WIX_W = 10
) (
   input  logic [WIX_W-1:0] wix,
   input  logic             is_wr,
   output sel_e             sel
);

   sel_e rd_sel, wr_sel;

   always_comb begin
      unique case (int'(wix))
         WIX_ID_A, WIX_ID_B, WIX_ID_C: rd_sel = SEL_ZERO;
         WIX_MEMSTAT:                  rd_sel = SEL_MEMSTAT;
         WIX_CLKDIV:                   rd_sel = SEL_CLKDIV;
         WIX_BUILD:                    rd_sel = SEL_BUILD;
         WIX_MEMCFG:                   rd_sel = SEL_MEMCFG;
         default:                      rd_sel = SEL_NONE;
      endcase
   end

   always_comb begin
      unique case (int'(wix))
         WIX_RSTCTL:                   wr_sel = SEL_RSTCTL;
         WIX_ID_A, WIX_ID_B, WIX_ID_C,
         WIX_MEMSTAT, WIX_LINKST,
         WIX_CLKDIV, WIX_BUILD,
         WIX_MEMCFG:                   wr_sel = SEL_DROP;
         default:                      wr_sel = SEL_NONE;
      endcase
   end

   assign sel = is_wr ? wr_sel : rd_sel;

endmodule

// File: rtl/plat_regfile_rdmux.sv
module plat_regfile_rdmux
   import plat_regfile_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int FREQ_W  = 8,
   parameter int MEMSZ_W = 4,
   parameter int SPEED_W = 12
) (
   input  logic               en,
   input  sel_e               sel,
   input  logic [FREQ_W-1:0]  clk_mhz,
   input  logic [MEMSZ_W-1:0] mem_gb,
   output logic [DATA_W-1:0]  rd_data
);

   localparam int FIELD_W = 8;
   localparam int SIZE_FW = 4;
   localparam int HI_PAD  = DATA_W - SIZE_FW - SPEED_W;

   logic [FIELD_W-1:0] freq_f;
   logic [SIZE_FW-1:0] size_f;

   generate
      if (FREQ_W == FIELD_W) begin : g_freq_full
         assign freq_f = clk_mhz;
      end else begin : g_freq_ext
         assign freq_f = {{(FIELD_W-FREQ_W){1'b0}}, clk_mhz};
      end
      if (MEMSZ_W == SIZE_FW) begin : g_size_full
         assign size_f = mem_gb;
      end else begin : g_size_ext
         assign size_f = {{(SIZE_FW-MEMSZ_W){1'b0}}, mem_gb};
      end
   endgenerate

   logic [DATA_W-1:0] w_memstat, w_clkdiv, w_build, w_memcfg, word;

   assign w_memstat = DATA_W'(32'h0000_0005);
   assign w_build   = DATA_W'(32'h0000_000E);
   assign w_clkdiv  = {8'd1, 8'd1, freq_f, 8'd1};
   assign w_memcfg  = {{HI_PAD{1'b0}}, {SPEED_W{1'b1}}, size_f};

   always_comb begin
      unique case (sel)
         SEL_MEMSTAT: word = w_memstat;
         SEL_CLKDIV:  word = w_clkdiv;
         SEL_BUILD:   word = w_build;
         SEL_MEMCFG:  word = w_memcfg;
         default:     word = '0;
      endcase
   end

   assign rd_data = en ? word : '0;

endmodule

// File: rtl/plat_regfile_rstreq.sv
module plat_regfile_rstreq #(
   parameter int DATA_W  = 32,
   parameter int RST_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              rst_req
);

   localparam logic [DATA_W-1:0] CMD_MASK = DATA_W'(1) << RST_BIT;

   logic fire;
   assign fire = hit && (|(wdata & CMD_MASK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req <= 1'b0;
      else        rst_req <= fire;
   end

endmodule

// File: rtl/plat_regfile.sv
module plat_regfile
   import plat_regfile_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int SIZE_W  = 4,
   parameter int FREQ_W  = 8,
   parameter int MEMSZ_W = 4,
   parameter int SPEED_W = 12,
   parameter int RST_BIT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_wr,
   input  logic [SIZE_W-1:0]  acc_size,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [DATA_W-1:0]  acc_wdata,
   input  logic [FREQ_W-1:0]  clk_mhz,
   input  logic [MEMSZ_W-1:0] mem_gb,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rst_req,
   output logic               unimpl
);

   localparam int WIX_W     = ADDR_W - 2;
   localparam int ACC_BYTES = DATA_W / 8;

   generate
      if (DATA_W != 32)               begin : g_bad_data  $error("DATA_W must be 32");        end
      if (ADDR_W < 6 || ADDR_W > 16)  begin : g_bad_addr  $error("ADDR_W out of range");      end
      if (FREQ_W < 1 || FREQ_W > 8)   begin : g_bad_freq  $error("FREQ_W must be 1..8");      end
      if (MEMSZ_W < 1 || MEMSZ_W > 4) begin : g_bad_mem   $error("MEMSZ_W must be 1..4");     end
      if (SPEED_W + 4 > DATA_W)       begin : g_bad_spd   $error("SPEED_W too wide");         end
      if (RST_BIT >= DATA_W)          begin : g_bad_rbit  $error("RST_BIT outside data");     end
      if ((1 << SIZE_W) <= ACC_BYTES) begin : g_bad_size  $error("SIZE_W too narrow");        end
   endgenerate

   logic fmt_ok, live;
   sel_e sel;

   assign fmt_ok = (acc_size == SIZE_W'(ACC_BYTES)) && (acc_addr[1:0] == 2'b00);
   assign live   = acc_valid && fmt_ok;

   plat_regfile_decode #(.WIX_W(WIX_W)) u_dec (
      .wix   (acc_addr[ADDR_W-1:2]),
      .is_wr (acc_wr),
      .sel   (sel)
   );

   plat_regfile_rdmux #(
      .DATA_W(DATA_W), .FREQ_W(FREQ_W), .MEMSZ_W(MEMSZ_W), .SPEED_W(SPEED_W)
   ) u_rd (
      .en      (live && !acc_wr),
      .sel     (sel),
      .clk_mhz (clk_mhz),
      .mem_gb  (mem_gb),
      .rd_data (rd_data)
   );

   plat_regfile_rstreq #(.DATA_W(DATA_W), .RST_BIT(RST_BIT)) u_rq (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (live && acc_wr && (sel == SEL_RSTCTL)),
      .wdata   (acc_wdata),
      .rst_req (rst_req)
   );

   assign unimpl = acc_valid && (!fmt_ok || (sel == SEL_NONE));

endmodule

// File: rtl/plat_regfile_chk.sv
module plat_regfile_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_valid,
   input logic        acc_wr,
   input logic [3:0]  acc_size,
   input logic [11:0] acc_addr,
   input logic [31:0] acc_wdata,
   input logic [7:0]  clk_mhz,
   input logic [31:0] rd_data,
   input logic        rst_req,
   input logic        unimpl
);

   logic cmd_wr, rd4;
   assign cmd_wr = acc_valid && acc_wr && acc_size == 4'd4 && acc_addr == 12'h010 && acc_wdata[4];
   assign rd4    = acc_valid && !acc_wr && acc_size == 4'd4;

   // R1
   bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_size != 4'd4) |-> (unimpl && rd_data == 32'h0));

   // R7
   rst_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> rst_req);

   // R7
   rst_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(cmd_wr));

   // R3
   memstat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd4 && acc_addr == 12'h014) |-> (rd_data == 32'h5 && !unimpl));

   // R4
   clkdiv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd4 && acc_addr == 12'h030) |-> (rd_data == {8'd1, 8'd1, clk_mhz, 8'd1}));

   // R10
   misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_addr[1:0] != 2'b00) |-> (unimpl && rd_data == 32'h0));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!unimpl && rd_data == 32'h0));

endmodule

bind plat_regfile plat_regfile_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_wr    (acc_wr),
   .acc_size  (acc_size),
   .acc_addr  (acc_addr),
   .acc_wdata (acc_wdata),
   .clk_mhz   (clk_mhz),
   .rd_data   (rd_data),
   .rst_req   (rst_req),
   .unimpl    (unimpl)
);

// File: tb/plat_regfile_bench.sv
`timescale 1ns/1ps
module plat_regfile_bench;

   typedef struct packed {
      logic        wr;
      logic [3:0]  sz;
      logic [11:0] addr;
      logic [31:0] wd;
      logic [31:0] rd;
      logic        un;
      logic        rq;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 24;
   // board inputs for the table: 50 MHz, 2 GB
   localparam vec_t VECS [NV] = '{
      '{1'b0, 4'd4, 12'h000, 32'h0,        32'h0,        1'b0, 1'b0, 8'd2},  // R2
      '{1'b0, 4'd4, 12'h004, 32'h0,        32'h0,        1'b0, 1'b0, 8'd2},  // R2
      '{1'b0, 4'd4, 12'h008, 32'h0,        32'h0,        1'b0, 1'b0, 8'd2},  // R2
      '{1'b0, 4'd4, 12'h014, 32'h0,        32'h5,        1'b0, 1'b0, 8'd3},  // R3
      '{1'b0, 4'd4, 12'h030, 32'h0,        32'h01013201, 1'b0, 1'b0, 8'd4},  // R4
      '{1'b0, 4'd4, 12'h034, 32'h0,        32'hE,        1'b0, 1'b0, 8'd5},  // R5
      '{1'b0, 4'd4, 12'h038, 32'h0,        32'h0000FFF2, 1'b0, 1'b0, 8'd6},  // R6
      '{1'b0, 4'd2, 12'h014, 32'h0,        32'h0,        1'b1, 1'b0, 8'd1},  // R1
      '{1'b0, 4'd8, 12'h030, 32'h0,        32'h0,        1'b1, 1'b0, 8'd1},  // R1
      '{1'b1, 4'd1, 12'h010, 32'h10,       32'h0,        1'b1, 1'b0, 8'd1},  // R1
      '{1'b1, 4'd4, 12'h010, 32'h10,       32'h0,        1'b0, 1'b1, 8'd7},  // R7
      '{1'b1, 4'd4, 12'h010, 32'hFFFFFFEF, 32'h0,        1'b0, 1'b0, 8'd7},  // R7
      '{1'b1, 4'd4, 12'h030, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0, 8'd8},  // R8
      '{1'b0, 4'd4, 12'h030, 32'h0,        32'h01013201, 1'b0, 1'b0, 8'd8},  // R8
      '{1'b1, 4'd4, 12'h018, 32'h10,       32'h0,        1'b0, 1'b0, 8'd8},  // R8
      '{1'b1, 4'd4, 12'h038, 32'h0,        32'h0,        1'b0, 1'b0, 8'd8},  // R8
      '{1'b0, 4'd4, 12'h038, 32'h0,        32'h0000FFF2, 1'b0, 1'b0, 8'd8},  // R8
      '{1'b0, 4'd4, 12'h018, 32'h0,        32'h0,        1'b1, 1'b0, 8'd9},  // R9
      '{1'b0, 4'd4, 12'h010, 32'h0,        32'h0,        1'b1, 1'b0, 8'd9},  // R9
      '{1'b0, 4'd4, 12'h00C, 32'h0,        32'h0,        1'b1, 1'b0, 8'd9},  // R9
      '{1'b1, 4'd4, 12'hFFC, 32'h10,       32'h0,        1'b1, 1'b0, 8'd9},  // R9
      '{1'b1, 4'd4, 12'h410, 32'h10,       32'h0,        1'b1, 1'b0, 8'd9},  // R9
      '{1'b0, 4'd4, 12'h016, 32'h0,        32'h0,        1'b1, 1'b0, 8'd10}, // R10
      '{1'b1, 4'd4, 12'h011, 32'h10,       32'h0,        1'b1, 1'b0, 8'd10}  // R10
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_wr = 1'b0;
   logic [3:0]  acc_size = 4'd0;
   logic [11:0] acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic [7:0]  clk_mhz = 8'd50;
   logic [3:0]  mem_gb = 4'd2;
   logic [31:0] rd_data;
   logic        rst_req, unimpl;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   plat_regfile u_plat_regfile (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wr(acc_wr),
      .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .clk_mhz(clk_mhz), .mem_gb(mem_gb), .rd_data(rd_data),
      .rst_req(rst_req), .unimpl(unimpl)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic access(input vec_t v);
      @(negedge clk);
      acc_valid = 1'b1; acc_wr = v.wr; acc_size = v.sz;
      acc_addr = v.addr; acc_wdata = v.wd;
      #1;
      check($sformatf("R%0d rd_data @%03h", v.req, v.addr), rd_data, v.rd);
      check($sformatf("R%0d unimpl @%03h", v.req, v.addr), 32'(unimpl), 32'(v.un));
      @(posedge clk); #1;
      check($sformatf("R%0d rst_req @%03h", v.req, v.addr), 32'(rst_req), 32'(v.rq));
   endtask

   task automatic idle();
      @(negedge clk);
      acc_valid = 1'b0; acc_wr = 1'b0; acc_size = 4'd0; acc_addr = '0; acc_wdata = '0;
   endtask

   initial begin
      // R11: reset state
      #1;
      check("R11 rst_req in reset", 32'(rst_req), 32'h0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check("R11 idle rd_data", rd_data, 32'h0);
      check("R11 idle unimpl", 32'(unimpl), 32'h0);
      check("R11 rst_req after reset", 32'(rst_req), 32'h0);

      for (int i = 0; i < NV; i++) access(VECS[i]);

      // R7: pulse lasts exactly one cycle
      access('{1'b1, 4'd4, 12'h010, 32'h10, 32'h0, 1'b0, 1'b1, 8'd7});
      idle();
      @(posedge clk); #1;
      check("R7 pulse single cycle", 32'(rst_req), 32'h0);

      // R11: read data zero during valid write to a readable word
      access('{1'b1, 4'd4, 12'h014, 32'h0, 32'h0, 1'b0, 1'b0, 8'd11});
      idle();

      // R4 R6: live board inputs
      clk_mhz = 8'hFF; mem_gb = 4'd1;
      access('{1'b0, 4'd4, 12'h030, 32'h0, 32'h0101FF01, 1'b0, 1'b0, 8'd4});
      access('{1'b0, 4'd4, 12'h038, 32'h0, 32'h0000FFF1, 1'b0, 1'b0, 8'd6});
      idle();
      #1;
      check("R11 idle unimpl end", 32'(unimpl), 32'h0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule